// File: doc/BRIEF.md
# Safety Supervisor Operating State Controller

This block is the sequencer of a safety companion device that watches over a microcontroller. It walks the device through five operating states: standby, reset, diagnostic, active and safe. It decides when the microcontroller is held in reset, when the safing path that lets the power stage drive may be enabled, and when the internal monitors run. It also decides when the self-test starts and which auxiliary regulators may be switched on.

The inputs are status flags and event pulses from blocks outside this one: wake-up, supply good, overvoltage, self-test done and self-test pass, watchdog good and bad events, and a fault from the microcontroller error-signal monitor. It also takes control bits that the microcontroller writes through its register interface. Two counters are kept. The watchdog fail count governs the safing-path enable and can force the safe state. The device error count records every entry into the safe state, and once it reaches a programmable limit the device goes back to standby instead of retrying.

Top module: `safe_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the state is standby (`state_o` = 0) and both counters are 0. In the same cycles `nres`, `endrv`, `bist_start` and the three monitor resets are all low.
- R2: The state code on `state_o` is standby=0, reset=1, diagnostic=2, active=3, safe=4. From standby, `wake` moves to reset. From reset, `supply_ok` moves to diagnostic. In diagnostic, active or safe, a low `supply_ok` moves to reset, and this takes priority over every other exit.
- R3: `spi_rst_n`, `wdg_rst_n` and `esm_rst_n` are low in standby and reset, and high in every other state.
- R4: `bist_start` is high for exactly the first cycle of each diagnostic visit. Diagnostic moves to active in the cycle after a passing result (`bist_done` and `bist_pass`) has been recorded during that visit while `ctl_go_active` is 1. A failing result (`bist_done` with `bist_pass` low) moves to safe.
- R5: `wd_fail_cnt` is reloaded to 5 on every entry into diagnostic or active. In those two states a lone `wd_good` decrements it, saturating at 0, and a lone `wd_bad` increments it, saturating at 7. Both pulses together, or neither, hold it. Events in any other state are ignored.
- R6: In diagnostic or active, with the supply good, a fail count of 7 or an `mcu_fault` moves to safe on the next clock.
- R7: `endrv` is high only in diagnostic or active, with `ctl_drv_en` = 1, `ov_flag` = 0 and a fail count below 5. It is low in standby, reset and safe.
- R8: If diagnostic is not left earlier, it is left for safe after exactly DIAG_TO cycles.
- R9: Safe is left after exactly SAFE_TO cycles unless the supply drops. The exit goes to standby when `dev_err_cnt` >= `err_limit`, and to reset otherwise.
- R10: `dev_err_cnt` increments by one on each entry into safe and saturates at 15. It changes at no other time, and only `rst_n` clears it.
- R11: `nres` is low in standby and reset, and stays low for NRES_EXT further cycles after reset is left.
- R12: `reg5_en` follows `ctl_reg5_en` and `regs_en` follows `ctl_regs_en` in diagnostic, active and safe. Both are forced low in standby and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wake | input | 1 | Wake-up request |
| supply_ok | input | 1 | Main supply good |
| ov_flag | input | 1 | Any supply overvoltage |
| bist_done | input | 1 | Self-test completion pulse |
| bist_pass | input | 1 | Self-test result, valid with bist_done |
| wd_good | input | 1 | Correct watchdog service event |
| wd_bad | input | 1 | Failed watchdog service event |
| mcu_fault | input | 1 | Microcontroller error-signal fault |
| ctl_drv_en | input | 1 | Control bit: allow safing-path enable |
| ctl_go_active | input | 1 | Control bit: request leaving diagnostic |
| ctl_reg5_en | input | 1 | Control bit: 5 V auxiliary regulator |
| ctl_regs_en | input | 1 | Control bit: sensor supply regulator |
| err_limit | input | 4 | Device error count that ends retries |
| nres | output | 1 | Microcontroller reset, active low |
| endrv | output | 1 | Safing-path enable |
| spi_rst_n | output | 1 | Serial interface reset, active low |
| wdg_rst_n | output | 1 | Watchdog reset, active low |
| esm_rst_n | output | 1 | Error-signal monitor reset, active low |
| bist_start | output | 1 | Self-test start pulse |
| reg5_en | output | 1 | 5 V auxiliary regulator enable |
| regs_en | output | 1 | Sensor supply regulator enable |
| state_o | output | 3 | Current state code |
| wd_fail_cnt | output | 3 | Watchdog fail count |
| dev_err_cnt | output | 4 | Device error count |

## Verification
The bench counts the cycles spent in diagnostic and in safe. A timer that is off by one, or that is not cleared on entry, shows up as a visit one cycle too long or too short. It drives the watchdog count from the reload value of 5 up to 7 and holds `wd_bad` high past that point. A counter that wraps, or that misses the forced exit, either drops below 5 and raises `endrv`, or leaves the design stuck in active. It runs enough safe visits to saturate the error count, and it sweeps `err_limit` so that both the retry exit and the give-up exit occur. It also drops the supply in the middle of diagnostic: a design that ranks a fault above supply loss goes to safe instead of reset.

// File: rtl/ssc_pkg.sv
// Shared types and constants for the safety state controller.
// Assumes: state codes are visible on a port, so their values are fixed.
package ssc_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_RESET   = 3'd1,
        ST_DIAG    = 3'd2,
        ST_ACTIVE  = 3'd3,
        ST_SAFE    = 3'd4
    } ssc_state_e;

    localparam int WDF_W         = 3;
    localparam int DEV_W         = 4;
    localparam int WDF_RELOAD    = 5;
    localparam int WDF_DRV_LIMIT = 5;
    localparam int WDF_MAX       = (1 << WDF_W) - 1;

endpackage

// File: rtl/ssc_seq.sv
// State sequencer: holds the operating state, one shared dwell timer,
// the recorded self-test pass and the self-test start pulse.
// Assumes: the counter inputs are registered values, so no combinational
// loop forms with ssc_counters.
module ssc_seq
    import ssc_pkg::*;
#(
    parameter int DIAG_TO = 40,
    parameter int SAFE_TO = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake,
    input  logic             supply_ok,
    input  logic             bist_done,
    input  logic             bist_pass,
    input  logic             mcu_fault,
    input  logic             go_active,
    input  logic [WDF_W-1:0] wdf,
    input  logic [DEV_W-1:0] dev,
    input  logic [DEV_W-1:0] err_limit,
    output ssc_state_e       state,
    output ssc_state_e       nxt,
    output logic             bist_start
);

    localparam int TMAX  = (DIAG_TO > SAFE_TO) ? DIAG_TO : SAFE_TO;
    localparam int TMR_W = $clog2(TMAX + 1);

    logic [TMR_W-1:0] tmr;
    logic             bist_ok;
    logic             diag_expire;
    logic             safe_expire;
    logic             fault_hit;

    assign diag_expire = (tmr == TMR_W'(DIAG_TO - 1));
    assign safe_expire = (tmr == TMR_W'(SAFE_TO - 1));
    assign fault_hit   = mcu_fault || (wdf == WDF_W'(WDF_MAX));

    // Next-state selection; supply loss ranks above every other exit.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STANDBY: if (wake) nxt = ST_RESET;
            ST_RESET:   if (supply_ok) nxt = ST_DIAG;
            ST_DIAG: begin
                if (!supply_ok)
                    nxt = ST_RESET;
                else if ((bist_done && !bist_pass) || fault_hit || diag_expire)
                    nxt = ST_SAFE;
                else if (bist_ok && go_active)
                    nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!supply_ok)
                    nxt = ST_RESET;
                else if (fault_hit)
                    nxt = ST_SAFE;
            end
            ST_SAFE: begin
                if (!supply_ok)
                    nxt = ST_RESET;
                else if (safe_expire)
                    nxt = (dev >= err_limit) ? ST_STANDBY : ST_RESET;
            end
            default: nxt = ST_STANDBY;
        endcase
    end

    // State register and the start pulse for a new diagnostic visit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_STANDBY;
            bist_start <= 1'b0;
        end else begin
            state      <= nxt;
            bist_start <= (nxt == ST_DIAG) && (state != ST_DIAG);
        end
    end

    // Dwell timer: cleared on every state change, saturating otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr <= '0;
        else if (nxt != state)
            tmr <= '0;
        else if (tmr != '1)
            tmr <= tmr + 1'b1;
    end

    // Records a passing self-test within the current diagnostic visit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bist_ok <= 1'b0;
        else
            bist_ok <= (state == ST_DIAG) && (bist_ok || (bist_done && bist_pass));
    end

endmodule

// File: rtl/ssc_counters.sv
// Watchdog fail counter and device error counter.
// Assumes: the state and next state come from ssc_seq. The error counter
// is cleared only by the power-on reset.
module ssc_counters
    import ssc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ssc_state_e       state,
    input  ssc_state_e       nxt,
    input  logic             wd_good,
    input  logic             wd_bad,
    output logic [WDF_W-1:0] wdf,
    output logic [DEV_W-1:0] dev
);

    logic [WDF_W-1:0] wdf_n;
    logic [DEV_W-1:0] dev_n;
    logic             entering;
    logic             supervised;

    assign entering   = (nxt != state);
    assign supervised = (state == ST_DIAG) || (state == ST_ACTIVE);

    // Fail count: reload on entry, otherwise saturating up/down on events.
    always_comb begin
        wdf_n = wdf;
        if (entering && (nxt == ST_DIAG || nxt == ST_ACTIVE))
            wdf_n = WDF_W'(WDF_RELOAD);
        else if (supervised) begin
            if (wd_bad && !wd_good && wdf != WDF_W'(WDF_MAX))
                wdf_n = wdf + 1'b1;
            else if (wd_good && !wd_bad && wdf != '0)
                wdf_n = wdf - 1'b1;
        end
    end

    // Error count: one step per safe entry, saturating at all ones.
    always_comb begin
        dev_n = dev;
        if (entering && nxt == ST_SAFE && dev != '1)
            dev_n = dev + 1'b1;
    end

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdf <= '0;
            dev <= '0;
        end else begin
            wdf <= wdf_n;
            dev <= dev_n;
        end
    end

endmodule

// File: rtl/ssc_outputs.sv
// Output stage: reset-release extension, safing-path gate, monitor resets
// and regulator enable gating.
// Assumes: the state and fail count are registered, so the outputs here
// depend only on flops and the quasi-static control inputs.
module ssc_outputs
    import ssc_pkg::*;
#(
    parameter int NRES_EXT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ssc_state_e       state,
    input  logic [WDF_W-1:0] wdf,
    input  logic             ov_flag,
    input  logic             drv_en,
    input  logic             reg5_ctl,
    input  logic             regs_ctl,
    output logic             nres,
    output logic             endrv,
    output logic             mon_rst_n,
    output logic             reg5_en,
    output logic             regs_en
);

    localparam int EXT_W = $clog2(NRES_EXT + 1);

    logic [EXT_W-1:0] ext;
    logic             held;
    logic             powered;

    assign held    = (state == ST_STANDBY) || (state == ST_RESET);
    assign powered = !held;

    // Extension counter: loaded in reset, runs down after reset is left.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext <= '0;
        else if (state == ST_RESET)
            ext <= EXT_W'(NRES_EXT);
        else if (ext != '0)
            ext <= ext - 1'b1;
    end

    // Output gating.
    always_comb begin
        nres      = !(held || (ext != '0));
        endrv     = ((state == ST_DIAG) || (state == ST_ACTIVE)) && drv_en &&
                    !ov_flag && (wdf < WDF_W'(WDF_DRV_LIMIT));
        mon_rst_n = powered;
        reg5_en   = powered && reg5_ctl;
        regs_en   = powered && regs_ctl;
    end

endmodule

// File: rtl/safe_state_ctrl.sv
// Top of the safety supervisor operating state controller. It wires the
// sequencer, the counters and the output stage together.
// Assumes: all inputs are synchronous to clk, and event inputs are
// single-cycle pulses.
module safe_state_ctrl
    import ssc_pkg::*;
#(
    parameter int DIAG_TO  = 40,
    parameter int SAFE_TO  = 20,
    parameter int NRES_EXT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake,
    input  logic       supply_ok,
    input  logic       ov_flag,
    input  logic       bist_done,
    input  logic       bist_pass,
    input  logic       wd_good,
    input  logic       wd_bad,
    input  logic       mcu_fault,
    input  logic       ctl_drv_en,
    input  logic       ctl_go_active,
    input  logic       ctl_reg5_en,
    input  logic       ctl_regs_en,
    input  logic [3:0] err_limit,
    output logic       nres,
    output logic       endrv,
    output logic       spi_rst_n,
    output logic       wdg_rst_n,
    output logic       esm_rst_n,
    output logic       bist_start,
    output logic       reg5_en,
    output logic       regs_en,
    output logic [2:0] state_o,
    output logic [2:0] wd_fail_cnt,
    output logic [3:0] dev_err_cnt
);

    ssc_state_e       state;
    ssc_state_e       nxt;
    logic [WDF_W-1:0] wdf;
    logic [DEV_W-1:0] dev;
    logic             mon_rst_n;

    ssc_seq #(
        .DIAG_TO (DIAG_TO),
        .SAFE_TO (SAFE_TO)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake       (wake),
        .supply_ok  (supply_ok),
        .bist_done  (bist_done),
        .bist_pass  (bist_pass),
        .mcu_fault  (mcu_fault),
        .go_active  (ctl_go_active),
        .wdf        (wdf),
        .dev        (dev),
        .err_limit  (err_limit),
        .state      (state),
        .nxt        (nxt),
        .bist_start (bist_start)
    );

    ssc_counters u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .nxt     (nxt),
        .wd_good (wd_good),
        .wd_bad  (wd_bad),
        .wdf     (wdf),
        .dev     (dev)
    );

    ssc_outputs #(
        .NRES_EXT (NRES_EXT)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .wdf       (wdf),
        .ov_flag   (ov_flag),
        .drv_en    (ctl_drv_en),
        .reg5_ctl  (ctl_reg5_en),
        .regs_ctl  (ctl_regs_en),
        .nres      (nres),
        .endrv     (endrv),
        .mon_rst_n (mon_rst_n),
        .reg5_en   (reg5_en),
        .regs_en   (regs_en)
    );

    // Port mapping of internal results.
    assign state_o     = state;
    assign wd_fail_cnt = wdf;
    assign dev_err_cnt = dev;
    assign spi_rst_n   = mon_rst_n;
    assign wdg_rst_n   = mon_rst_n;
    assign esm_rst_n   = mon_rst_n;

endmodule

// File: rtl/ssc_checker.sv
// Temporal checks on the controller's ports, bound to safe_state_ctrl.
// Assumes: rst_n is held low for at least two clocks when it is applied.
module ssc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wake,
    input logic       supply_ok,
    input logic [2:0] state_o,
    input logic [2:0] wd_fail_cnt,
    input logic [3:0] dev_err_cnt,
    input logic       endrv,
    input logic       nres,
    input logic       bist_start,
    input logic       reg5_en,
    input logic       regs_en
);

    // R2: a wake in standby leads to reset.
    p_wake_to_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && wake) |=> (state_o == 3'd1));

    // R4: the start pulse is a single cycle.
    p_bist_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bist_start |=> !bist_start);

    // R5: a fresh diagnostic visit begins with the reload value.
    p_wdf_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) != 3'd2) |-> (wd_fail_cnt == 3'd5));

    // R6: a full fail count with a good supply forces safe.
    p_wd_full_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd2 || state_o == 3'd3) && wd_fail_cnt == 3'd7 && supply_ok)
        |=> (state_o == 3'd4));

    // R7: no safing-path enable outside diagnostic and active.
    p_endrv_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd4) |-> !endrv);

    // R10: safe entry steps the error count by one, saturating.
    p_dev_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |->
        (dev_err_cnt == (($past(dev_err_cnt) == 4'd15) ? 4'd15 : $past(dev_err_cnt) + 4'd1)));

    // R10: without a state change the error count does not move.
    p_dev_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == $past(state_o)) |-> $stable(dev_err_cnt));

    // R11: the microcontroller reset is held in standby and reset.
    p_nres_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd1) |-> !nres);

    // R12: the regulators stay off in standby and reset.
    p_regs_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd1) |-> (!reg5_en && !regs_en));

endmodule

bind safe_state_ctrl ssc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake        (wake),
    .supply_ok   (supply_ok),
    .state_o     (state_o),
    .wd_fail_cnt (wd_fail_cnt),
    .dev_err_cnt (dev_err_cnt),
    .endrv       (endrv),
    .nres        (nres),
    .bist_start  (bist_start),
    .reg5_en     (reg5_en),
    .regs_en     (regs_en)
);

// File: tb/safe_state_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random stimulus, compared
// every cycle against a reference model built from the requirements.
module safe_state_ctrl_tb;

    localparam int DIAG_TO  = 40;
    localparam int SAFE_TO  = 20;
    localparam int NRES_EXT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 0, supply_ok = 0, ov_flag = 0, bist_done = 0, bist_pass = 0;
    logic wd_good = 0, wd_bad = 0, mcu_fault = 0;
    logic ctl_drv_en = 0, ctl_go_active = 0, ctl_reg5_en = 0, ctl_regs_en = 0;
    logic [3:0] err_limit = 4'd15;
    logic nres, endrv, spi_rst_n, wdg_rst_n, esm_rst_n, bist_start, reg5_en, regs_en;
    logic [2:0] state_o, wd_fail_cnt;
    logic [3:0] dev_err_cnt;

    int checks = 0;
    int fails = 0;
    bit chk_en = 0;
    bit done = 0;

    always #10 clk = ~clk;

    safe_state_ctrl #(.DIAG_TO(DIAG_TO), .SAFE_TO(SAFE_TO), .NRES_EXT(NRES_EXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wake(wake), .supply_ok(supply_ok), .ov_flag(ov_flag),
        .bist_done(bist_done), .bist_pass(bist_pass), .wd_good(wd_good), .wd_bad(wd_bad),
        .mcu_fault(mcu_fault), .ctl_drv_en(ctl_drv_en), .ctl_go_active(ctl_go_active),
        .ctl_reg5_en(ctl_reg5_en), .ctl_regs_en(ctl_regs_en), .err_limit(err_limit),
        .nres(nres), .endrv(endrv), .spi_rst_n(spi_rst_n), .wdg_rst_n(wdg_rst_n),
        .esm_rst_n(esm_rst_n), .bist_start(bist_start), .reg5_en(reg5_en),
        .regs_en(regs_en), .state_o(state_o), .wd_fail_cnt(wd_fail_cnt),
        .dev_err_cnt(dev_err_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model registers.
    int m_st = 0, m_tmr = 0, m_wdf = 0, m_dev = 0, m_ext = 0, m_bok = 0, m_bst = 0;

    function automatic int model_next();
        int n = m_st;
        bit flt = mcu_fault || (m_wdf == 7);
        case (m_st)
            0: if (wake) n = 1;
            1: if (supply_ok) n = 2;
            2: if (!supply_ok) n = 1;
               else if ((bist_done && !bist_pass) || flt || m_tmr == DIAG_TO - 1) n = 4;
               else if (m_bok != 0 && ctl_go_active) n = 3;
            3: if (!supply_ok) n = 1; else if (flt) n = 4;
            4: if (!supply_ok) n = 1;
               else if (m_tmr == SAFE_TO - 1) n = (m_dev >= int'(err_limit)) ? 0 : 1;
            default: n = 0;
        endcase
        return n;
    endfunction

    // Model update on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_wdf = 0; m_dev = 0; m_ext = 0; m_bok = 0; m_bst = 0;
        end else begin
            int n;
            n = model_next();
            m_bst = (n == 2 && m_st != 2) ? 1 : 0;
            m_bok = (m_st == 2 && (m_bok != 0 || (bist_done && bist_pass))) ? 1 : 0;
            if (m_st == 1) m_ext = NRES_EXT; else if (m_ext > 0) m_ext--;
            if (n != m_st && (n == 2 || n == 3)) m_wdf = 5;
            else if (m_st == 2 || m_st == 3) begin
                if (wd_bad && !wd_good && m_wdf < 7) m_wdf++;
                else if (wd_good && !wd_bad && m_wdf > 0) m_wdf--;
            end
            if (n == 4 && m_st != 4 && m_dev < 15) m_dev++;
            if (n != m_st) m_tmr = 0; else if (m_tmr < 63) m_tmr++;
            m_st = n;
        end
    end

    // Per-cycle comparison, sampled away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (chk_en) begin
            bit held;
            held = (m_st <= 1);
            chk("R2 state", state_o, m_st);
            chk("R5 wd_fail_cnt", wd_fail_cnt, m_wdf);
            chk("R10 dev_err_cnt", dev_err_cnt, m_dev);
            chk("R11 nres", nres, (held || m_ext != 0) ? 0 : 1);
            chk("R7 endrv", endrv, ((m_st == 2 || m_st == 3) && ctl_drv_en && !ov_flag && m_wdf < 5) ? 1 : 0);
            chk("R3 monitor resets", {spi_rst_n, wdg_rst_n, esm_rst_n}, held ? 0 : 7);
            chk("R4 bist_start", bist_start, m_bst);
            chk("R12 reg5_en", reg5_en, (!held && ctl_reg5_en) ? 1 : 0);
            chk("R12 regs_en", regs_en, (!held && ctl_regs_en) ? 1 : 0);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_state(input int s, input int maxc, input string tag);
        int n = 0;
        #2;
        while (int'(state_o) != s && n < maxc) begin
            @(negedge clk); #2; n++;
        end
        chk(tag, state_o, s);
    endtask

    // Watchdog on the whole run.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5a5;
        void'($urandom(seed));
        repeat (3) tick();
        #2;
        // R1: values while reset is held.
        chk("R1 state in reset", state_o, 0);
        chk("R1 nres in reset", nres, 0);
        chk("R1 counters in reset", {wd_fail_cnt, dev_err_cnt}, 0);
        tick(); rst_n = 1; chk_en = 1;
        #2;
        chk("R1 state after release", state_o, 0);
        chk("R1 endrv after release", endrv, 0);

        // R8 / R9 / R11: diagnostic time-out, then safe time-out to standby.
        tick(); supply_ok = 1; err_limit = 4'd1; ctl_drv_en = 1;
        ctl_reg5_en = 1; ctl_regs_en = 1; wake = 1;
        tick(); wake = 0;
        wait_state(2, 10, "R2 reach diagnostic");
        begin
            int nd = 0, nl = 0;
            while (state_o == 3'd2) begin
                nd++; if (!nres) nl++;
                @(negedge clk); #2;
            end
            chk("R8 diagnostic dwell", nd, DIAG_TO);
            chk("R11 nres extension", nl, NRES_EXT);
        end
        chk("R8 exit to safe", state_o, 4);
        begin
            int ns = 0;
            while (state_o == 3'd4) begin ns++; @(negedge clk); #2; end
            chk("R9 safe dwell", ns, SAFE_TO);
        end
        chk("R9 give up to standby", state_o, 0);

        // R4 / R5 / R6 / R7: active, watchdog events, forced safe.
        tick(); err_limit = 4'd15; wake = 1;
        tick(); wake = 0;
        wait_state(2, 10, "R2 diagnostic again");
        tick(); bist_done = 1; bist_pass = 1; ctl_go_active = 1;
        tick(); bist_done = 0; bist_pass = 0;
        wait_state(3, 5, "R4 pass leads to active");
        chk("R5 reload on active entry", wd_fail_cnt, 5);
        tick(); wd_good = 1;
        tick(); wd_good = 0; #2;
        chk("R5 good event decrements", wd_fail_cnt, 4);
        chk("R7 endrv enabled", endrv, 1);
        tick(); ov_flag = 1; #2;
        chk("R7 overvoltage gates endrv", endrv, 0);
        tick(); ov_flag = 0; wd_bad = 1;
        wait_state(4, 8, "R6 full fail count forces safe");
        chk("R5 saturates at 7", wd_fail_cnt, 7);
        tick(); #2;
        chk("R5 events ignored in safe", wd_fail_cnt, 7);
        wd_bad = 0;
        wait_state(1, SAFE_TO + 2, "R9 retry through reset");
        wait_state(2, 5, "R2 reset to diagnostic");

        // R4: failing self-test.
        tick(); bist_done = 1; bist_pass = 0;
        tick(); bist_done = 0;
        wait_state(4, 3, "R4 failing self-test to safe");
        chk("R10 third safe entry", dev_err_cnt, 3);
        wait_state(2, SAFE_TO + 6, "R2 back to diagnostic");

        // R2 / R3 / R12: supply loss wins over a simultaneous fault.
        tick(); supply_ok = 0; mcu_fault = 1;
        tick(); mcu_fault = 0; #2;
        chk("R2 supply loss to reset", state_o, 1);
        chk("R3 monitors held", spi_rst_n, 0);
        chk("R12 regulator forced off", reg5_en, 0);
        tick(); supply_ok = 1;

        // Random phase.
        for (int i = 0; i < 20000; i++) begin
            tick();
            wake          = ($urandom_range(3) == 0);
            supply_ok     = ($urandom_range(99) > 2);
            ov_flag       = ($urandom_range(19) == 0);
            bist_done     = ($urandom_range(9) == 0);
            bist_pass     = ($urandom_range(4) != 0);
            wd_good       = ($urandom_range(3) == 0);
            wd_bad        = ($urandom_range(5) == 0);
            mcu_fault     = ($urandom_range(99) == 0);
            ctl_go_active = $urandom_range(1);
            ctl_drv_en    = ($urandom_range(3) != 0);
            ctl_reg5_en   = $urandom_range(1);
            ctl_regs_en   = $urandom_range(1);
            if (i % 500 == 0)
                err_limit = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : 4'd15;
        end
        #2;
        chk("R10 saturated after many safe entries", (dev_err_cnt == 4'd15) ? 1 : 0, 1);

        // R10: only the power-on reset clears the error count.
        tick(); rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick(); #2;
        chk("R10 cleared by reset", dev_err_cnt, 0);
        chk("R1 standby after reset", state_o, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule